// File: doc/BRIEF.md
# Multi-mode Ethernet transmit pin mapper

This block sits at the transmit edge of an Ethernet port. It places outgoing traffic onto one fixed group of pins: eight data pins, one enable or control pin and one error pin. Six wiring schemes share these pins. Three of them carry MAC bytes one clock at a time, either as a full octet, as a nibble or as a dibit. One carries an already encoded 10-bit line code group in a single clock. Two are double-rate schemes that split a byte or a code group over the rising and falling halves of the clock.

The scheme is chosen by a static selector, which is captured only while reset is held. Double-rate pins are described as two values for each pin, one for the rising half and one for the falling half. Both halves are registered together on each rising edge, so an output stage outside this block can drive the real pins from them without special cells here. In single-rate schemes the two halves are equal.

Bytes enter through a valid/ready stream. A byte moves when `s_valid` and `s_ready` are both high at a rising edge. While `s_valid` is high and `s_ready` is low, the source must hold `s_data` and `s_err` steady. A clock in which no byte is being sent puts enable low. Code groups enter through their own valid/ready stream. Its ready output is high in every clock while a code-group scheme is selected and reset is low. A transferred byte or code group starts to appear on the pins after the rising edge that follows the transfer.

Top module: `eth_tx_pinmap`

## Requirements
- R1: The scheme selector (`mode_sel`) and the slow-speed flag (`speed_10m`) are captured only at rising edges while `rst` is high. Changing them after reset has no effect on the pins.
- R2: After any rising edge with `rst` high, every pin output is low. Both `s_ready` and `cg_ready` are low while `rst` is high.
- R3: Selector 0 (full byte per clock): `txd_rise` and `txd_fall` both equal the byte, both control halves equal 1, and `tx_er` is the byte's error flag. Consecutive bytes go out on consecutive clocks.
- R4: Selector 1 (nibble per clock): data pins 3:0 carry the low nibble first and the high nibble in the next clock. Pins 7:4 are 0 and `tx_er` is the byte's error flag.
- R5: Selector 2 (dibit per clock): data pins 1:0 carry bits 1:0, 3:2, 5:4 and 7:6 over four clocks in that order. Pins 7:2 are 0 and `tx_er` stays 0.
- R6: Selector 3 (code group, single rate): data pins 7:0 carry code bits 7:0, the control pin carries code bit 8 and `tx_er` carries code bit 9. Both halves are equal.
- R7: Selector 4 (byte, double rate): the rising half of data pins 3:0 carries byte bits 3:0 and the falling half carries bits 7:4. The control pin carries enable in the rising half and the error flag in the falling half. `tx_er` stays 0.
- R8: Selector 5 (code group, double rate): the rising half of data pins 3:0 carries code bits 3:0 and the falling half carries bits 8:5. The control pin carries code bit 4 in the rising half and bit 9 in the falling half. `tx_er` stays 0.
- R9: In the byte schemes, a clock without a byte being sent has all data pins, both control halves and `tx_er` at 0. The error flag is never driven while enable is low.
- R10: With `speed_10m` captured as 1, `s_err` has no effect: every error output stays 0 while the data still goes out.
- R11: `s_ready` is low while earlier bytes still have beats left to put out. A held byte is therefore sent exactly once, and bytes sent back to back leave no idle clock between them.
- R12: Selector values 6 and 7 behave as selector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; selector capture window |
| mode_sel | input | 3 | Scheme selector: 0 byte, 1 nibble, 2 dibit, 3 code group, 4 double-rate byte, 5 double-rate code group |
| speed_10m | input | 1 | Slow-speed flag; suppresses the error flag when captured high |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready |
| s_data | input | 8 | Byte to send |
| s_err | input | 1 | Error flag for this byte |
| cg_valid | input | 1 | Code group stream valid |
| cg_ready | output | 1 | Code group stream ready |
| cg_data | input | 10 | Code group to send |
| txd_rise | output | 8 | Data pin values for the rising half |
| txd_fall | output | 8 | Data pin values for the falling half |
| txctl_rise | output | 1 | Enable/control pin value for the rising half |
| txctl_fall | output | 1 | Enable/control pin value for the falling half |
| tx_er | output | 1 | Error pin |

## Verification
The hardest case to reach is a byte stalled at the stream boundary while an earlier byte still has beats on the pins. A wrong ready would then send the held byte twice or drop a beat. The bench holds `s_valid` and an unchanged byte across the nibble scheme's busy clock, probes `s_ready` at each falling edge, and then swaps in a new byte at the exact clock where ready returns. The pin stream is recorded and matched beat by beat. The second delicate case is a selector that changes after reset. It is driven by releasing reset in one scheme and then moving `mode_sel` to another before any traffic is sent.

// File: rtl/eth_txmap_pkg.sv
package eth_txmap_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CG_W   = 10;
  localparam int unsigned HALF_W = BYTE_W / 2;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CNT_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    TXM_GMII  = 3'd0,
    TXM_MII   = 3'd1,
    TXM_RMII  = 3'd2,
    TXM_TBI   = 3'd3,
    TXM_RGMII = 3'd4,
    TXM_RTBI  = 3'd5
  } txm_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] d_rise;
    logic [BYTE_W-1:0] d_fall;
    logic              c_rise;
    logic              c_fall;
    logic              err;
  } pin_set_t;

  // Number of clocks one byte occupies on the pins.
  function automatic logic [CNT_W:0] beats_of(txm_mode_e m);
    case (m)
      TXM_MII:  return 3'd2;
      TXM_RMII: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

  // Bits of a byte carried per clock.
  function automatic logic [3:0] lane_of(txm_mode_e m);
    case (m)
      TXM_MII:  return 4'd4;
      TXM_RMII: return 4'd2;
      default:  return 4'd8;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] lane_mask(txm_mode_e m);
    case (m)
      TXM_MII:  return 8'h0F;
      TXM_RMII: return 8'h03;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic is_code_mode(txm_mode_e m);
    return (m == TXM_TBI) || (m == TXM_RTBI);
  endfunction

endpackage

// File: rtl/txm_mode_latch.sv
module txm_mode_latch
  import eth_txmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] mode_sel,
  input  logic             speed_10m,
  output txm_mode_e        mode_q,
  output logic             slow_q,
  output logic             byte_en,
  output logic             code_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= speed_10m;
      case (mode_sel)
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5: mode_q <= txm_mode_e'(mode_sel);
        default:                            mode_q <= TXM_GMII;
      endcase
    end
  end

  always_comb begin
    code_en = is_code_mode(mode_q);
    byte_en = !code_en;
  end

  // R1: the captured scheme does not move once reset is gone
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mode_q) && $stable(slow_q)));

endmodule

// File: rtl/txm_byte_serializer.sv
module txm_byte_serializer
  import eth_txmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  txm_mode_e         mode,
  input  logic              slow,
  input  logic              byte_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_err,
  output logic              u_en,
  output logic              u_err,
  output logic [BYTE_W-1:0] u_data
);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W:0]    n_beats;
  logic [3:0]        lw;
  logic [BYTE_W-1:0] mask;
  logic              take;

  always_comb begin
    n_beats = beats_of(mode);
    lw      = lane_of(mode);
    mask    = lane_mask(mode);
    s_ready = byte_en && !rst && (rem == '0);
    take    = s_valid && s_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      rem    <= '0;
      u_en   <= 1'b0;
      u_err  <= 1'b0;
      u_data <= '0;
    end else if (take) begin
      u_en   <= 1'b1;
      u_err  <= s_err && !slow;
      u_data <= s_data & mask;
      shreg  <= s_data >> lw;
      rem    <= CNT_W'(n_beats - 1'b1);
    end else if (rem != '0) begin
      u_data <= shreg & mask;
      shreg  <= shreg >> lw;
      rem    <= rem - 1'b1;
    end else begin
      u_en   <= 1'b0;
      u_err  <= 1'b0;
      u_data <= '0;
    end
  end

  // R10: slow speed never lets an error through
  p_slow_no_err_r10: assert property (@(posedge clk) disable iff (rst)
    slow |-> !u_err);

  // R4: a byte with beats left keeps enable up on the next clock
  p_beat_run_r4: assert property (@(posedge clk) disable iff (rst)
    (u_en && rem != '0) |=> u_en);

  // R9: no error without enable at the unit stage
  p_err_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    u_err |-> u_en);

endmodule

// File: rtl/txm_code_stage.sv
module txm_code_stage
  import eth_txmap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            code_en,
  input  logic            cg_valid,
  output logic            cg_ready,
  input  logic [CG_W-1:0] cg_data,
  output logic [CG_W-1:0] c_data
);

  always_comb cg_ready = code_en && !rst;

  always_ff @(posedge clk) begin
    if (rst) c_data <= '0;
    else if (cg_valid && cg_ready) c_data <= cg_data;
    else c_data <= '0;
  end

  // R6: a code group that is not taken leaves nothing on the stage
  p_cg_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !code_en |=> (c_data == '0));

endmodule

// File: rtl/txm_pin_encoder.sv
module txm_pin_encoder
  import eth_txmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  txm_mode_e         mode,
  input  logic              u_en,
  input  logic              u_err,
  input  logic [BYTE_W-1:0] u_data,
  input  logic [CG_W-1:0]   c_data,
  output pin_set_t          pins_q
);

  pin_set_t pins_d;

  always_comb begin
    pins_d = '0;
    case (mode)
      TXM_GMII, TXM_MII: begin
        pins_d.d_rise = u_data;
        pins_d.d_fall = u_data;
        pins_d.c_rise = u_en;
        pins_d.c_fall = u_en;
        pins_d.err    = u_err && u_en;
      end
      TXM_RMII: begin
        pins_d.d_rise = u_data;
        pins_d.d_fall = u_data;
        pins_d.c_rise = u_en;
        pins_d.c_fall = u_en;
      end
      TXM_TBI: begin
        pins_d.d_rise = c_data[BYTE_W-1:0];
        pins_d.d_fall = c_data[BYTE_W-1:0];
        pins_d.c_rise = c_data[8];
        pins_d.c_fall = c_data[8];
        pins_d.err    = c_data[9];
      end
      TXM_RGMII: begin
        pins_d.d_rise = {{HALF_W{1'b0}}, u_data[HALF_W-1:0]};
        pins_d.d_fall = {{HALF_W{1'b0}}, u_data[BYTE_W-1:HALF_W]};
        pins_d.c_rise = u_en;
        pins_d.c_fall = u_err && u_en;
      end
      TXM_RTBI: begin
        pins_d.d_rise = {{HALF_W{1'b0}}, c_data[3:0]};
        pins_d.d_fall = {{HALF_W{1'b0}}, c_data[8:5]};
        pins_d.c_rise = c_data[4];
        pins_d.c_fall = c_data[9];
      end
      default: pins_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins_d;
  end

  // R2: a reset edge leaves every pin low
  p_reset_quiet_r2: assert property (@(posedge clk)
    rst |=> (pins_q == '0));

  // R9: no byte in flight means quiet data and error pins
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!u_en && !is_code_mode(mode)) |=>
      (pins_q.d_rise == '0 && pins_q.d_fall == '0 && !pins_q.err));

endmodule

// File: rtl/eth_tx_pinmap.sv
module eth_tx_pinmap
  import eth_txmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  mode_sel,
  input  logic        speed_10m,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_err,
  input  logic        cg_valid,
  output logic        cg_ready,
  input  logic [9:0]  cg_data,
  output logic [7:0]  txd_rise,
  output logic [7:0]  txd_fall,
  output logic        txctl_rise,
  output logic        txctl_fall,
  output logic        tx_er
);

  txm_mode_e         mode_q;
  logic              slow_q;
  logic              byte_en;
  logic              code_en;
  logic              u_en;
  logic              u_err;
  logic [BYTE_W-1:0] u_data;
  logic [CG_W-1:0]   c_data;
  pin_set_t          pins_q;

  txm_mode_latch u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .speed_10m (speed_10m),
    .mode_q    (mode_q),
    .slow_q    (slow_q),
    .byte_en   (byte_en),
    .code_en   (code_en)
  );

  txm_byte_serializer u_ser (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .slow    (slow_q),
    .byte_en (byte_en),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_err   (s_err),
    .u_en    (u_en),
    .u_err   (u_err),
    .u_data  (u_data)
  );

  txm_code_stage u_code (
    .clk      (clk),
    .rst      (rst),
    .code_en  (code_en),
    .cg_valid (cg_valid),
    .cg_ready (cg_ready),
    .cg_data  (cg_data),
    .c_data   (c_data)
  );

  txm_pin_encoder u_enc (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .u_en   (u_en),
    .u_err  (u_err),
    .u_data (u_data),
    .c_data (c_data),
    .pins_q (pins_q)
  );

  always_comb begin
    txd_rise   = pins_q.d_rise;
    txd_fall   = pins_q.d_fall;
    txctl_rise = pins_q.c_rise;
    txctl_fall = pins_q.c_fall;
    tx_er      = pins_q.err;
  end

  // R5 R7 R8: error pin stays low in the schemes that do not use it
  p_er_unused_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TXM_RMII || mode_q == TXM_RGMII || mode_q == TXM_RTBI) |-> !tx_er);

  // R9: error pin only rises inside an enabled clock
  p_er_with_en_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_er && (mode_q == TXM_GMII || mode_q == TXM_MII)) |-> txctl_rise);

  // R2: no handshake is offered while reset is held
  p_ready_in_reset_r2: assert property (@(posedge clk)
    rst |-> (!s_ready && !cg_ready));

endmodule

// File: tb/eth_tx_pinmap_bench.sv
`timescale 1ns/1ps
module eth_tx_pinmap_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic       speed_10m = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       s_err = 1'b0;
  logic       cg_valid = 1'b0;
  logic       cg_ready;
  logic [9:0] cg_data = 10'h000;
  logic [7:0] txd_rise, txd_fall;
  logic       txctl_rise, txctl_fall, tx_er;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  eth_tx_pinmap u_eth_tx_pinmap (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .speed_10m(speed_10m),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_err(s_err),
    .cg_valid(cg_valid), .cg_ready(cg_ready), .cg_data(cg_data),
    .txd_rise(txd_rise), .txd_fall(txd_fall),
    .txctl_rise(txctl_rise), .txctl_fall(txctl_fall), .tx_er(tx_er)
  );

  // pin recorder, one entry per falling edge
  logic [7:0] rec_dr [64];
  logic [7:0] rec_df [64];
  logic       rec_cr [64];
  logic       rec_cf [64];
  logic       rec_er [64];
  int         n_rec = 0;
  logic       rec_on = 1'b0;
  int         base = 0;

  always @(negedge clk) begin
    if (rec_on && n_rec < 64) begin
      rec_dr[n_rec] = txd_rise;
      rec_df[n_rec] = txd_fall;
      rec_cr[n_rec] = txctl_rise;
      rec_cf[n_rec] = txctl_fall;
      rec_er[n_rec] = tx_er;
      n_rec++;
    end
  end

  logic [7:0] tb_b  [16];
  logic       tb_e  [16];
  logic [9:0] tb_cg [16];

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk(input int idx, input logic [7:0] dr, input logic [7:0] df,
                     input logic cr, input logic cf, input logic er, input string tag);
    int k;
    k = base + idx;
    n_vec++;
    if (k >= n_rec || base < 0) begin
      n_bad++;
      $display("FAIL %s: beat %0d not recorded, expected %h/%h %b%b%b", tag, idx, dr, df, cr, cf, er);
    end else if (rec_dr[k] !== dr || rec_df[k] !== df || rec_cr[k] !== cr ||
                 rec_cf[k] !== cf || rec_er[k] !== er) begin
      n_bad++;
      $display("FAIL %s: beat %0d got %h/%h %b%b%b expected %h/%h %b%b%b", tag, idx,
               rec_dr[k], rec_df[k], rec_cr[k], rec_cf[k], rec_er[k], dr, df, cr, cf, er);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic slow);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; speed_10m = slow;
    s_valid = 1'b0; cg_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic rec_start();
    n_rec = 0; rec_on = 1'b1;
  endtask

  task automatic rec_stop();
    repeat (8) @(negedge clk);
    rec_on = 1'b0;
    base = -1;
    for (int i = 0; i < n_rec; i++) begin
      if (base < 0 && (rec_dr[i] != 0 || rec_df[i] != 0 || rec_cr[i] || rec_cf[i] || rec_er[i]))
        base = i;
    end
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = tb_b[i]; s_err = tb_e[i];
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_valid = 1'b0; s_err = 1'b0; s_data = 8'h00;
  endtask

  task automatic send_cgs(input int n);
    for (int i = 0; i < n; i++) begin
      cg_valid = 1'b1; cg_data = tb_cg[i];
      #1;
      while (!cg_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    cg_valid = 1'b0; cg_data = 10'h000;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mode_sel = 3'd0; s_valid = 1'b1; s_data = 8'hFF; s_err = 1'b1;
    cg_valid = 1'b1; cg_data = 10'h3FF;
    repeat (3) @(negedge clk);
    check_bit(txd_rise == 8'h00 && txd_fall == 8'h00, 1'b1, "R2 data pins in reset");
    check_bit(txctl_rise | txctl_fall | tx_er, 1'b0, "R2 control/error in reset");
    check_bit(s_ready | cg_ready, 1'b0, "R2 ready in reset");
    s_valid = 1'b0; s_err = 1'b0; cg_valid = 1'b0;
  endtask

  task automatic t_gmii();
    do_reset(3'd0, 1'b0);
    tb_b[0] = 8'hA7; tb_e[0] = 1'b0;
    tb_b[1] = 8'h3C; tb_e[1] = 1'b1;
    tb_b[2] = 8'h81; tb_e[2] = 1'b0;
    rec_start(); send_bytes(3); rec_stop();
    chk(0, 8'hA7, 8'hA7, 1, 1, 0, "R3 byte0");
    chk(1, 8'h3C, 8'h3C, 1, 1, 1, "R3 byte1 with error");
    chk(2, 8'h81, 8'h81, 1, 1, 0, "R3 byte2");
    chk(3, 8'h00, 8'h00, 0, 0, 0, "R9 idle after frame");
  endtask

  task automatic t_mii();
    do_reset(3'd1, 1'b0);
    tb_b[0] = 8'h96; tb_e[0] = 1'b1;
    tb_b[1] = 8'h4E; tb_e[1] = 1'b0;
    rec_start(); send_bytes(2); rec_stop();
    chk(0, 8'h06, 8'h06, 1, 1, 1, "R4 low nibble first");
    chk(1, 8'h09, 8'h09, 1, 1, 1, "R4 high nibble");
    chk(2, 8'h0E, 8'h0E, 1, 1, 0, "R4 next byte low nibble");
    chk(3, 8'h04, 8'h04, 1, 1, 0, "R4 next byte high nibble");
    chk(4, 8'h00, 8'h00, 0, 0, 0, "R9 idle after nibbles");
  endtask

  task automatic t_rmii();
    do_reset(3'd2, 1'b0);
    tb_b[0] = 8'b10_01_11_00; tb_e[0] = 1'b1;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'h00, 8'h00, 1, 1, 0, "R5 dibit0");
    chk(1, 8'h03, 8'h03, 1, 1, 0, "R5 dibit1");
    chk(2, 8'h01, 8'h01, 1, 1, 0, "R5 dibit2");
    chk(3, 8'h02, 8'h02, 1, 1, 0, "R5 dibit3");
    chk(4, 8'h00, 8'h00, 0, 0, 0, "R9 idle after dibits");
  endtask

  task automatic t_tbi();
    do_reset(3'd3, 1'b0);
    tb_cg[0] = 10'b10_1100_0101;
    tb_cg[1] = 10'b01_0011_1010;
    tb_cg[2] = 10'b11_1111_0000;
    rec_start(); send_cgs(3); rec_stop();
    for (int i = 0; i < 3; i++)
      chk(i, tb_cg[i][7:0], tb_cg[i][7:0], tb_cg[i][8], tb_cg[i][8], tb_cg[i][9], "R6 code group");
  endtask

  task automatic t_rgmii();
    do_reset(3'd4, 1'b0);
    tb_b[0] = 8'hD2; tb_e[0] = 1'b0;
    tb_b[1] = 8'h5B; tb_e[1] = 1'b1;
    rec_start(); send_bytes(2); rec_stop();
    chk(0, 8'h02, 8'h0D, 1, 0, 0, "R7 halves byte0");
    chk(1, 8'h0B, 8'h05, 1, 1, 0, "R7 halves byte1 error on falling");
    chk(2, 8'h00, 8'h00, 0, 0, 0, "R9 idle after double-rate");
  endtask

  task automatic t_rtbi();
    do_reset(3'd5, 1'b0);
    tb_cg[0] = 10'b1_0110_1_1001;
    tb_cg[1] = 10'b0_1001_0_0110;
    rec_start(); send_cgs(2); rec_stop();
    for (int i = 0; i < 2; i++)
      chk(i, {4'h0, tb_cg[i][3:0]}, {4'h0, tb_cg[i][8:5]}, tb_cg[i][4], tb_cg[i][9], 1'b0,
          "R8 double-rate code group");
  endtask

  task automatic t_slow();
    do_reset(3'd1, 1'b1);
    tb_b[0] = 8'h7F; tb_e[0] = 1'b1;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'h0F, 8'h0F, 1, 1, 0, "R10 error ignored at slow speed");
    chk(1, 8'h07, 8'h07, 1, 1, 0, "R10 error ignored second nibble");
    do_reset(3'd4, 1'b1);
    tb_b[0] = 8'h12; tb_e[0] = 1'b1;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'h02, 8'h01, 1, 0, 0, "R10 double-rate error half ignored");
  endtask

  task automatic t_backpressure();
    do_reset(3'd1, 1'b0);
    rec_start();
    s_valid = 1'b1; s_data = 8'hA5; s_err = 1'b0;
    #1 check_bit(s_ready, 1'b1, "R11 ready when idle");
    @(negedge clk);
    #1 check_bit(s_ready, 1'b0, "R11 ready low while beats remain");
    @(negedge clk);
    #1 check_bit(s_ready, 1'b1, "R11 ready back on last beat");
    s_data = 8'h3C;
    @(negedge clk);
    s_valid = 1'b0; s_data = 8'h00;
    rec_stop();
    chk(0, 8'h05, 8'h05, 1, 1, 0, "R11 held byte low nibble");
    chk(1, 8'h0A, 8'h0A, 1, 1, 0, "R11 held byte high nibble");
    chk(2, 8'h0C, 8'h0C, 1, 1, 0, "R11 next byte no gap");
    chk(3, 8'h03, 8'h03, 1, 1, 0, "R11 next byte high nibble");
    chk(4, 8'h00, 8'h00, 0, 0, 0, "R11 byte sent once");
  endtask

  task automatic t_mode_change();
    do_reset(3'd1, 1'b0);
    mode_sel = 3'd0; speed_10m = 1'b1;
    repeat (2) @(negedge clk);
    tb_b[0] = 8'hC9; tb_e[0] = 1'b1;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'h09, 8'h09, 1, 1, 1, "R1 scheme and speed held after reset");
    chk(1, 8'h0C, 8'h0C, 1, 1, 1, "R1 still nibble scheme");
  endtask

  task automatic t_bad_mode();
    do_reset(3'd7, 1'b0);
    tb_b[0] = 8'h5A; tb_e[0] = 1'b0;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'h5A, 8'h5A, 1, 1, 0, "R12 selector 7 as full byte");
    do_reset(3'd6, 1'b0);
    tb_b[0] = 8'hE1; tb_e[0] = 1'b1;
    rec_start(); send_bytes(1); rec_stop();
    chk(0, 8'hE1, 8'hE1, 1, 1, 1, "R12 selector 6 as full byte");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_gmii();
    t_mii();
    t_rmii();
    t_tbi();
    t_rgmii();
    t_rtbi();
    t_slow();
    t_backpressure();
    t_mode_change();
    t_bad_mode();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule